// File: doc/BRIEF.md
# Multi-Format Integer Divider

This block is a sequential integer divider. It serves four operand formats from one shift-and-subtract datapath. A two-bit format code and a signedness input pick the format. The host presents the operands and pulses `start` while the block is idle. The dividend may come from the low word alone or from both words. The divisor may be its low half or its full word. The block then produces one quotient bit per clock on operand magnitudes. In a final cycle it applies the sign rules, checks the quotient against the destination width, and updates the result outputs together with the status flags.

A zero divisor and a quotient too large for the destination are both reported on their own outputs. In either case the result outputs keep their previous contents, so a later exception stage can act on the flags without seeing a partial result. The negative and zero flags describe the quotient. The carry flag is always low.

Top module: `idiv_mf`

## Requirements
- R1: With `mode` = 0 (word format), the low 32 bits of the dividend are divided by divisor bits [15:0]. `quo` receives the remainder in bits [31:16] and the quotient in bits [15:0]. `rem` is not changed.
- R2: With `mode` = 1 (long, quotient only), a 32-bit dividend is divided by a 32-bit divisor. Only `quo` is updated, and `rem` keeps its previous value.
- R3: With `mode` = 2 (extended), the 64-bit dividend {`dvd_hi`,`dvd_lo`} is divided by the 32-bit divisor. The 32-bit quotient goes to `quo` and the 32-bit remainder goes to `rem`.
- R4: With `mode` = 3 (split), `dvd_lo` is divided by the 32-bit divisor. The quotient goes to `quo` and the remainder goes to `rem`.
- R5: When `sign_en` = 1, operands are two's complement, and in word format the divisor is sign-extended from bit 15. The quotient truncates toward zero and the remainder carries the sign of the dividend. When `sign_en` = 0, all operands are unsigned.
- R6: A divisor that is zero in the bits the format uses sets `div_zero` and clears `ovf`. `quo` and `rem` are left unchanged.
- R7: If the exact quotient does not fit the destination, `ovf` is set and `div_zero` is cleared. The destination is 16 bits in word format and 32 bits otherwise, signed or unsigned as selected. `quo` and `rem` are left unchanged.
- R8: On a valid result, `flag_n` is the quotient's sign bit (bit 15 in word format, bit 31 otherwise) and `flag_z` is 1 when the quotient is zero. Both flags are 0 after a zero divisor or an overflow. `flag_c` is always 0.
- R9: `done` is a one-cycle pulse. It rises on the (K+1)-th rising edge after the edge that samples `start`, where K = 64 in extended format, K = 32 in the other formats, and K = 0 for a zero divisor. `busy` is high from the sampling edge until `done` rises.
- R10: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own operands and its own latency.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled while idle |
| mode | input | 2 | Format: 0 word, 1 long quotient, 2 extended, 3 split |
| sign_en | input | 1 | 1 selects signed division |
| dvd_hi | input | 32 | Upper dividend word (extended format only) |
| dvd_lo | input | 32 | Lower dividend word |
| dsr | input | 32 | Divisor (bits [15:0] in word format) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quo | output | 32 | Quotient, or packed remainder:quotient in word format |
| rem | output | 32 | Remainder for the extended and split formats |
| div_zero | output | 1 | Last operation had a zero divisor |
| ovf | output | 1 | Last operation overflowed its destination |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_c | output | 1 | Carry, always 0 |

## Verification
The properties assume that `rst_n` is applied from time zero and that operands are needed only on the edge that accepts `start`. They also assume that `start` is never raised in the same cycle as `done`, so the latency counter in the checker always refers to one operation. The stimulus drives every input at falling edges and raises `start` for a single cycle while the block is idle. It waits for `done` before presenting the next vector. The one exception is a deliberate second pulse issued in the middle of a run.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

   typedef enum logic [1:0] {
      FMT_WORD   = 2'd0,
      FMT_LONG_Q = 2'd1,
      FMT_EXT    = 2'd2,
      FMT_SPLIT  = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } st_e;

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
   import idiv_pkg::*;
#(
   parameter int W = 32
) (
   input  fmt_e               fmt,
   input  logic               sign_en,
   input  logic [W-1:0]       dvd_hi,
   input  logic [W-1:0]       dvd_lo,
   input  logic [W-1:0]       dsr,
   output logic [2*W-1:0]     dvd_mag,
   output logic [W-1:0]       dsr_mag,
   output logic               neg_q,
   output logic               neg_r,
   output logic               zero_dsr,
   output logic               ext
);
   localparam int DW   = 2 * W;
   localparam int HALF = W / 2;

   logic [DW-1:0] dvd_full;
   logic [W-1:0]  dsr_full;
   logic          dvd_neg;
   logic          dsr_neg;
   logic          is_word;

   always_comb begin
      ext     = (fmt == FMT_EXT);
      is_word = (fmt == FMT_WORD);

      if (ext)
         dvd_full = {dvd_hi, dvd_lo};
      else if (sign_en)
         dvd_full = {{W{dvd_lo[W-1]}}, dvd_lo};
      else
         dvd_full = {{W{1'b0}}, dvd_lo};

      if (!is_word)
         dsr_full = dsr;
      else if (sign_en)
         dsr_full = {{HALF{dsr[HALF-1]}}, dsr[HALF-1:0]};
      else
         dsr_full = {{HALF{1'b0}}, dsr[HALF-1:0]};

      dvd_neg  = sign_en & dvd_full[DW-1];
      dsr_neg  = sign_en & dsr_full[W-1];
      dvd_mag  = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
      dsr_mag  = dsr_neg ? (~dsr_full + 1'b1) : dsr_full;
      neg_q    = dvd_neg ^ dsr_neg;
      neg_r    = dvd_neg;
      zero_dsr = (dsr_full == '0);
   end

endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
   parameter int W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               ext,
   input  logic [2*W-1:0]     dvd_mag,
   input  logic [W-1:0]       dsr_mag,
   output logic               last,
   output logic [2*W-1:0]     qmag,
   output logic [W-1:0]       rmag
);
   localparam int DW = 2 * W;
   localparam int CW = $clog2(DW + 1);

   logic [DW-1:0] acc_q;
   logic [W-1:0]  part_q;
   logic [W-1:0]  dsr_q;
   logic [CW-1:0] cnt_q;
   logic [W:0]    trial;
   logic [W:0]    diff;
   logic          take;

   always_comb begin
      trial = {part_q, acc_q[DW-1]};
      diff  = trial - {1'b0, dsr_q};
      take  = (trial >= {1'b0, dsr_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         part_q <= '0;
         dsr_q  <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         acc_q  <= ext ? dvd_mag : {dvd_mag[W-1:0], {W{1'b0}}};
         part_q <= '0;
         dsr_q  <= dsr_mag;
         cnt_q  <= ext ? CW'(DW) : CW'(W);
      end else if (step) begin
         part_q <= take ? diff[W-1:0] : trial[W-1:0];
         acc_q  <= {acc_q[DW-2:0], take};
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CW'(1));
   assign qmag = acc_q;
   assign rmag = part_q;

endmodule

// File: rtl/idiv_fix.sv
module idiv_fix
   import idiv_pkg::*;
#(
   parameter int W = 32
) (
   input  fmt_e               fmt,
   input  logic               sign_en,
   input  logic               neg_q,
   input  logic               neg_r,
   input  logic [2*W-1:0]     qmag,
   input  logic [W-1:0]       rmag,
   output logic               too_big,
   output logic [W-1:0]       qval,
   output logic [W-1:0]       rval,
   output logic               n_out,
   output logic               z_out
);
   localparam int DW   = 2 * W;
   localparam int HALF = W / 2;
   localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};
   localparam logic [DW-1:0] HS_POS = (ONE << (HALF - 1)) - ONE;
   localparam logic [DW-1:0] HS_NEG = ONE << (HALF - 1);
   localparam logic [DW-1:0] HU_MAX = (ONE << HALF) - ONE;
   localparam logic [DW-1:0] FS_POS = (ONE << (W - 1)) - ONE;
   localparam logic [DW-1:0] FS_NEG = ONE << (W - 1);
   localparam logic [DW-1:0] FU_MAX = (ONE << W) - ONE;

   logic [DW-1:0] limit;
   logic [W-1:0]  qs;
   logic [W-1:0]  rs;
   logic          is_word;

   always_comb begin
      is_word = (fmt == FMT_WORD);
      if (is_word)
         limit = !sign_en ? HU_MAX : (neg_q ? HS_NEG : HS_POS);
      else
         limit = !sign_en ? FU_MAX : (neg_q ? FS_NEG : FS_POS);
      too_big = (qmag > limit);

      qs = neg_q ? (~qmag[W-1:0] + 1'b1) : qmag[W-1:0];
      rs = neg_r ? (~rmag + 1'b1) : rmag;
      rval = rs;
      if (is_word) begin
         qval  = {rs[HALF-1:0], qs[HALF-1:0]};
         n_out = qs[HALF-1];
         z_out = (qs[HALF-1:0] == '0);
      end else begin
         qval  = qs;
         n_out = qs[W-1];
         z_out = (qs == '0);
      end
   end

endmodule

// File: rtl/idiv_mf.sv
module idiv_mf
   import idiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         mode,
   input  logic               sign_en,
   input  logic [W-1:0]       dvd_hi,
   input  logic [W-1:0]       dvd_lo,
   input  logic [W-1:0]       dsr,
   output logic               busy,
   output logic               done,
   output logic [W-1:0]       quo,
   output logic [W-1:0]       rem,
   output logic               div_zero,
   output logic               ovf,
   output logic               flag_n,
   output logic               flag_z,
   output logic               flag_c
);
   localparam int DW = 2 * W;

   generate
      if (W < 8) begin : g_bad_width
         $error("idiv_mf: W must be at least 8");
      end
      if ((W % 2) != 0) begin : g_bad_half
         $error("idiv_mf: W must be even so the word format splits cleanly");
      end
   endgenerate

   st_e           st_q;
   fmt_e          fmt_in;
   fmt_e          fmt_q;
   logic          sign_q;
   logic          negq_q;
   logic          negr_q;
   logic          dz_q;

   logic [DW-1:0] p_dvd_mag;
   logic [W-1:0]  p_dsr_mag;
   logic          p_neg_q;
   logic          p_neg_r;
   logic          p_zero;
   logic          p_ext;

   logic          accept;
   logic          core_load;
   logic          core_step;
   logic          core_last;
   logic [DW-1:0] core_q;
   logic [W-1:0]  core_r;

   logic          f_big;
   logic [W-1:0]  f_q;
   logic [W-1:0]  f_r;
   logic          f_n;
   logic          f_z;

   assign fmt_in    = fmt_e'(mode);
   assign accept    = (st_q == ST_IDLE) && start;
   assign core_load = accept && !p_zero;
   assign core_step = (st_q == ST_RUN);
   assign busy      = (st_q != ST_IDLE);
   assign flag_c    = 1'b0;

   idiv_prep #(.W(W)) prep_i (
      .fmt      (fmt_in),
      .sign_en  (sign_en),
      .dvd_hi   (dvd_hi),
      .dvd_lo   (dvd_lo),
      .dsr      (dsr),
      .dvd_mag  (p_dvd_mag),
      .dsr_mag  (p_dsr_mag),
      .neg_q    (p_neg_q),
      .neg_r    (p_neg_r),
      .zero_dsr (p_zero),
      .ext      (p_ext)
   );

   idiv_core #(.W(W)) core_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (core_load),
      .step    (core_step),
      .ext     (p_ext),
      .dvd_mag (p_dvd_mag),
      .dsr_mag (p_dsr_mag),
      .last    (core_last),
      .qmag    (core_q),
      .rmag    (core_r)
   );

   idiv_fix #(.W(W)) fix_i (
      .fmt     (fmt_q),
      .sign_en (sign_q),
      .neg_q   (negq_q),
      .neg_r   (negr_q),
      .qmag    (core_q),
      .rmag    (core_r),
      .too_big (f_big),
      .qval    (f_q),
      .rval    (f_r),
      .n_out   (f_n),
      .z_out   (f_z)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fmt_q  <= FMT_WORD;
         sign_q <= 1'b0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         dz_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  fmt_q  <= fmt_in;
                  sign_q <= sign_en;
                  negq_q <= p_neg_q;
                  negr_q <= p_neg_r;
                  dz_q   <= p_zero;
                  st_q   <= p_zero ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (core_last)
                  st_q <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         quo      <= '0;
         rem      <= '0;
         div_zero <= 1'b0;
         ovf      <= 1'b0;
         flag_n   <= 1'b0;
         flag_z   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st_q == ST_FIN) begin
            done <= 1'b1;
            if (dz_q) begin
               div_zero <= 1'b1;
               ovf      <= 1'b0;
               flag_n   <= 1'b0;
               flag_z   <= 1'b0;
            end else if (f_big) begin
               div_zero <= 1'b0;
               ovf      <= 1'b1;
               flag_n   <= 1'b0;
               flag_z   <= 1'b0;
            end else begin
               div_zero <= 1'b0;
               ovf      <= 1'b0;
               flag_n   <= f_n;
               flag_z   <= f_z;
               quo      <= f_q;
               if (fmt_q == FMT_EXT || fmt_q == FMT_SPLIT)
                  rem <= f_r;
            end
         end
      end
   end

endmodule

// File: rtl/idiv_mf_chk.sv
module idiv_mf_chk #(
   parameter int W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [W-1:0]       quo,
   input logic [W-1:0]       rem,
   input logic               div_zero,
   input logic               ovf,
   input logic               flag_n,
   input logic               flag_z
);
   localparam int LW = $clog2(2 * W + 2) + 1;

   logic [LW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lat_q <= '0;
      else if (start && !busy)
         lat_q <= '0;
      else if (busy)
         lat_q <= lat_q + 1'b1;
   end

   // R6, R7: one exception cause at a time
   p_one_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(div_zero && ovf));

   p_hold_quo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (ovf || div_zero)) |-> $stable(quo));

   p_hold_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (ovf || div_zero)) |-> $stable(rem));

   p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (ovf || div_zero)) |-> (!flag_n && !flag_z));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(1) || lat_q == LW'(W + 1) || lat_q == LW'(2 * W + 1)));

   p_busy_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quo) && $stable(rem)));

endmodule

bind idiv_mf idiv_mf_chk #(.W(W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .quo      (quo),
   .rem      (rem),
   .div_zero (div_zero),
   .ovf      (ovf),
   .flag_n   (flag_n),
   .flag_z   (flag_z)
);

// File: tb/idiv_mf_tb_top.sv
`timescale 1ns/1ps
module idiv_mf_tb_top;

   typedef struct packed {
      logic [1:0]  md;
      logic        sg;
      logic [31:0] hi;
      logic [31:0] lo;
      logic [31:0] dv;
      logic        eo;
      logic        ez;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b0, 32'h0,        32'd100000,   32'd7,        1'b0, 1'b0},
      '{2'd0, 1'b1, 32'h0,        32'hFFFFFF9C, 32'd7,        1'b0, 1'b0},
      '{2'd0, 1'b0, 32'h0,        32'h00100000, 32'd1,        1'b1, 1'b0},
      '{2'd0, 1'b1, 32'h0,        32'h80000000, 32'h0000FFFF, 1'b1, 1'b0},
      '{2'd1, 1'b0, 32'h0,        32'hFFFFFFFF, 32'd3,        1'b0, 1'b0},
      '{2'd1, 1'b1, 32'h0,        32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0},
      '{2'd1, 1'b1, 32'h0,        32'hFFFFFFF9, 32'd2,        1'b0, 1'b0},
      '{2'd2, 1'b0, 32'h1,        32'h0,        32'd2,        1'b0, 1'b0},
      '{2'd2, 1'b0, 32'h2,        32'h0,        32'd2,        1'b1, 1'b0},
      '{2'd2, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'd2,        1'b0, 1'b0},
      '{2'd2, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1,        1'b0, 1'b0},
      '{2'd2, 1'b1, 32'h0,        32'h80000000, 32'd1,        1'b1, 1'b0},
      '{2'd3, 1'b1, 32'h0,        32'd7,        32'hFFFFFFFE, 1'b0, 1'b0},
      '{2'd3, 1'b0, 32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0},
      '{2'd3, 1'b0, 32'h0,        32'd5,        32'd0,        1'b0, 1'b1},
      '{2'd0, 1'b1, 32'h0,        32'd5,        32'h00010000, 1'b0, 1'b1},
      '{2'd0, 1'b1, 32'h0,        32'h00008000, 32'h0000FFFF, 1'b0, 1'b0},
      '{2'd0, 1'b1, 32'h0,        32'h00008000, 32'd1,        1'b1, 1'b0},
      '{2'd2, 1'b0, 32'h0,        32'd100,      32'd7,        1'b0, 1'b0},
      '{2'd3, 1'b1, 32'h0,        32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b0},
      '{2'd0, 1'b0, 32'h0,        32'd1000,     32'hABCD0010, 1'b0, 1'b0},
      '{2'd3, 1'b0, 32'h0,        32'd3,        32'd5,        1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        sign_en = 1'b0;
   logic [31:0] dvd_hi = '0;
   logic [31:0] dvd_lo = '0;
   logic [31:0] dsr = '0;
   logic        busy, done, div_zero, ovf, flag_n, flag_z, flag_c;
   logic [31:0] quo, rem;

   int n_checks = 0;
   int n_fails  = 0;
   logic [31:0] m_quo = '0;
   logic [31:0] m_rem = '0;

   always #2.5 clk = ~clk;

   idiv_mf #(.W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sign_en(sign_en),
      .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dsr(dsr), .busy(busy), .done(done),
      .quo(quo), .rem(rem), .div_zero(div_zero), .ovf(ovf),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   // Reference from the requirements: exact wide arithmetic
   task automatic model(input vec_t v, output logic e_dz, output logic e_ov,
                        output logic e_n, output logic e_z);
      logic signed [127:0] a, b, q, r, lim;
      int lw;
      logic fits;
      if (v.md == 2'd2)
         a = v.sg ? {{64{v.hi[31]}}, v.hi, v.lo} : {64'b0, v.hi, v.lo};
      else
         a = v.sg ? {{96{v.lo[31]}}, v.lo} : {96'b0, v.lo};
      if (v.md == 2'd0)
         b = v.sg ? {{112{v.dv[15]}}, v.dv[15:0]} : {112'b0, v.dv[15:0]};
      else
         b = v.sg ? {{96{v.dv[31]}}, v.dv} : {96'b0, v.dv};
      lw = (v.md == 2'd0) ? 16 : 32;
      e_n = 1'b0;
      e_z = 1'b0;
      e_ov = 1'b0;
      e_dz = (b == 0);
      if (!e_dz) begin
         q = a / b;
         r = a % b;
         if (v.sg) begin
            lim = 128'sd1 <<< (lw - 1);
            fits = (q >= -lim) && (q < lim);
         end else begin
            lim = 128'sd1 <<< lw;
            fits = (q < lim);
         end
         e_ov = !fits;
         if (fits) begin
            if (v.md == 2'd0) begin
               m_quo = {r[15:0], q[15:0]};
               e_n = q[15];
               e_z = (q[15:0] == 16'h0);
            end else begin
               m_quo = q[31:0];
               e_n = q[31];
               e_z = (q[31:0] == 32'h0);
               if (v.md[1]) m_rem = r[31:0];
            end
         end
      end
   endtask

   task automatic launch(input vec_t v);
      @(negedge clk);
      mode = v.md; sign_en = v.sg; dvd_hi = v.hi; dvd_lo = v.lo; dsr = v.dv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // counts rising edges from the start-sampling edge to the one raising done
   task automatic wait_done(output int edges);
      edges = 1;
      while (!done && edges < 300) begin
         @(negedge clk);
         edges++;
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      logic e_dz, e_ov, e_n, e_z;
      int edges, exp_edges;
      launch(v);
      check("R9 busy after start", 64'(busy), 64'd1);
      wait_done(edges);
      model(v, e_dz, e_ov, e_n, e_z);
      exp_edges = e_dz ? 2 : (v.md == 2'd2 ? 66 : 34);
      $display("vector %0d mode %0d signed %0d", idx, v.md, v.sg);
      check("R9 latency", 64'(edges), 64'(exp_edges));
      check("R6 div_zero", 64'(div_zero), 64'(v.ez));
      check("R7 ovf", 64'(ovf), 64'(v.eo));
      check("R6 model agrees on zero divisor", 64'(e_dz), 64'(v.ez));
      check("R7 model agrees on overflow", 64'(e_ov), 64'(v.eo));
      check("R1 R2 R3 R4 R5 quo", 64'(quo), 64'(m_quo));
      check("R1 R2 R3 R4 R5 rem", 64'(rem), 64'(m_rem));
      check("R8 flag_n", 64'(flag_n), 64'(e_n));
      check("R8 flag_z", 64'(flag_z), 64'(e_z));
      check("R8 flag_c", 64'(flag_c), 64'd0);
      check("R9 busy low at done", 64'(busy), 64'd0);
      @(negedge clk);
      check("R9 done pulse single", 64'(done), 64'd0);
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      vec_t va, vb;
      int edges;
      logic e_dz, e_ov, e_n, e_z;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 busy", 64'(busy), 64'd0);
      check("R11 done", 64'(done), 64'd0);
      check("R11 quo", 64'(quo), 64'd0);
      check("R11 rem", 64'(rem), 64'd0);
      check("R11 flags", 64'({div_zero, ovf, flag_n, flag_z, flag_c}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

      // R10: a second start during a run is ignored
      va = '{2'd3, 1'b0, 32'h0, 32'd100, 32'd7, 1'b0, 1'b0};
      vb = '{2'd2, 1'b1, 32'h0, 32'd5, 32'd0, 1'b0, 1'b1};
      launch(va);
      repeat (4) @(negedge clk);
      mode = vb.md; sign_en = vb.sg; dvd_lo = vb.lo; dsr = vb.dv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(edges);
      model(va, e_dz, e_ov, e_n, e_z);
      check("R10 latency kept", 64'(edges + 5), 64'd34);
      check("R10 quo from first op", 64'(quo), 64'd14);
      check("R10 rem from first op", 64'(rem), 64'd2);
      check("R10 no zero divisor seen", 64'(div_zero), 64'd0);
      @(negedge clk);
      finish_run();
   end

endmodule